// File: doc/BRIEF.md
# Packed Vector Element Permute Unit

This block rearranges the lanes of 64-bit packed operands for a media datapath. It takes two vector sources, an 8-bit immediate, a 32-bit scalar and a 4-bit operation code. It returns either a rearranged 64-bit vector or a 32-bit scalar. The operations are:

- interleaving the upper or lower halves of both sources at 8-, 16- or 32-bit element size;
- reading one 16-bit word out to the scalar result;
- writing the scalar's low word into one lane;
- a four-word shuffle controlled by the immediate;
- exchanging the two 32-bit halves of the second source.

All lane placement is decided by a combinational network. One result register at the output captures each accepted request. The register is loaded in the cycle after `in_valid`, and that load is flagged by a one-cycle `out_valid` pulse. Throughout, "first source" means `src_a` and "second source" means `src_b`. Word k of a vector is bits [16k+15:16k], and element i of any size counts upward from bit 0.

Top module: `perm_unit`

## Requirements
- R1: Low interleave, op 0 (bytes), 1 (words) and 2 (doublewords), reads only bits [31:0] of each source. Result element 2i is element i of `src_a` and result element 2i+1 is element i of `src_b`, so the word form gives {b1,a1,b0,a0} from the top lane down.
- R2: High interleave, op 4 (bytes), 5 (words) and 6 (doublewords), places elements by the rule of R1 but reads only bits [63:32] of each source. The lower halves have no effect on the result.
- R3: Extract, op 8, returns word `imm[1:0]` of `src_b`, zero-extended to 32 bits, on `scal_q`, and drives `vec_q` to zero.
- R4: Insert, op 9, returns `src_a` with word `imm[1:0]` replaced by `scal_in[15:0]`. The other three words pass through unchanged, and `scal_q` is zero.
- R5: For extract and insert, bits [7:2] of the immediate have no effect.
- R6: Shuffle, op 10, sets result word k to word `imm[2k+1:2k]` of `src_b` for k = 0 to 3. `src_a` has no effect.
- R7: Swap, op 11, returns {`src_b[31:0]`, `src_b[63:32]`}. `src_a` has no effect.
- R8: A request with `in_valid` high is loaded into `vec_q`/`scal_q` at the next rising edge, and `out_valid` is high for exactly that one cycle. With `in_valid` low, the outputs hold their values and `out_valid` is low.
- R9: Synchronous active-high `rst` clears `vec_q`, `scal_q` and `out_valid`.
- R10: Op codes 3, 7 and 12 to 15 return all-zero results. Every op other than extract returns a zero `scal_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| src_a | input | 64 | First vector source |
| src_b | input | 64 | Second vector source |
| imm | input | 8 | Lane-select immediate |
| scal_in | input | 32 | Scalar source for insert |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| vec_q | output | 64 | Registered vector result |
| scal_q | output | 32 | Registered scalar result |

## Verification
The bench swaps the halves that each interleave must ignore. A design that read the wrong half would change its result. Its sources differ in every byte, so a lane-order mix-up (a and b swapped, or elements placed in the wrong lanes) shows up as a wrong value. Extract is run on words whose top bit is set, which catches sign extension. Extract and insert are run with junk in the upper immediate bits, which catches lane decoding that uses more than two bits. Shuffle is run with the identity and broadcast patterns. Swap and shuffle are run with a changed first source. Other runs drop `in_valid`, apply reset mid-stream and use unused op codes; these catch a result register that loads on every cycle or is not cleared.

// File: rtl/perm_pkg.sv
package perm_pkg;

    localparam int VEC_W  = 64;
    localparam int WORD_W = 16;
    localparam int SCAL_W = 32;
    localparam int IMM_W  = 8;
    localparam int OP_W   = 4;
    localparam int HALF_W = VEC_W / 2;
    localparam int NWORD  = VEC_W / WORD_W;
    localparam int SEL_W  = $clog2(NWORD);

    typedef enum logic [OP_W-1:0] {
        OP_ILV_LO_B = 4'd0,
        OP_ILV_LO_W = 4'd1,
        OP_ILV_LO_D = 4'd2,
        OP_ILV_HI_B = 4'd4,
        OP_ILV_HI_W = 4'd5,
        OP_ILV_HI_D = 4'd6,
        OP_EXTRACT  = 4'd8,
        OP_INSERT   = 4'd9,
        OP_SHUFFLE  = 4'd10,
        OP_SWAP     = 4'd11
    } perm_op_e;

    typedef struct packed {
        logic [VEC_W-1:0]  vec;
        logic [SCAL_W-1:0] scal;
    } perm_res_t;

    // Interleave ops carry granularity in bits [1:0] and half in bit 2.
    function automatic logic is_interleave(input logic [OP_W-1:0] code);
        return (code[OP_W-1] == 1'b0) && (code[1:0] != 2'b11);
    endfunction

endpackage

// File: rtl/perm_interleave.sv
module perm_interleave #(
    parameter int VEC_W = 64
) (
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic             use_hi,
    input  logic [1:0]       gran,
    output logic [VEC_W-1:0] ilv
);
    localparam int HALF_W = VEC_W / 2;
    localparam int NSIZE  = 3;

    logic [HALF_W-1:0] half_a, half_b;

    assign half_a = use_hi ? src_a[VEC_W-1:HALF_W] : src_a[HALF_W-1:0];
    assign half_b = use_hi ? src_b[VEC_W-1:HALF_W] : src_b[HALF_W-1:0];

    for (genvar g = 0; g < NSIZE; g++) begin : g_sz
        localparam int EW = 8 << g;
        localparam int NE = HALF_W / EW;
        logic [VEC_W-1:0] res;
        always_comb begin
            res = '0;
            for (int i = 0; i < NE; i++) begin
                res[(2*i)*EW   +: EW] = half_a[i*EW +: EW];
                res[(2*i+1)*EW +: EW] = half_b[i*EW +: EW];
            end
        end
    end

    always_comb begin
        case (gran)
            2'd0:    ilv = g_sz[0].res;
            2'd1:    ilv = g_sz[1].res;
            2'd2:    ilv = g_sz[2].res;
            default: ilv = '0;
        endcase
    end

endmodule

// File: rtl/perm_words.sv
module perm_words #(
    parameter int VEC_W  = 64,
    parameter int WORD_W = 16,
    parameter int SCAL_W = 32,
    parameter int IMM_W  = 8
) (
    input  logic [VEC_W-1:0]  src_a,
    input  logic [VEC_W-1:0]  src_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic [SCAL_W-1:0] scal_in,
    output logic [VEC_W-1:0]  shuf,
    output logic [SCAL_W-1:0] ext,
    output logic [VEC_W-1:0]  ins,
    output logic [VEC_W-1:0]  swp
);
    localparam int NWORD  = VEC_W / WORD_W;
    localparam int SEL_W  = $clog2(NWORD);
    localparam int HALF_W = VEC_W / 2;

    logic [SEL_W-1:0] lane;
    assign lane = imm[SEL_W-1:0];

    always_comb begin
        shuf = '0;
        for (int k = 0; k < NWORD; k++) begin
            shuf[k*WORD_W +: WORD_W] =
                src_b[int'(imm[k*SEL_W +: SEL_W])*WORD_W +: WORD_W];
        end
    end

    always_comb begin
        ext = '0;
        ext[WORD_W-1:0] = src_b[int'(lane)*WORD_W +: WORD_W];
    end

    always_comb begin
        ins = src_a;
        ins[int'(lane)*WORD_W +: WORD_W] = scal_in[WORD_W-1:0];
    end

    assign swp = {src_b[HALF_W-1:0], src_b[VEC_W-1:HALF_W]};

endmodule

// File: rtl/perm_unit.sv
module perm_unit
    import perm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op,
    input  logic [VEC_W-1:0]  src_a,
    input  logic [VEC_W-1:0]  src_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic [SCAL_W-1:0] scal_in,
    output logic              out_valid,
    output logic [VEC_W-1:0]  vec_q,
    output logic [SCAL_W-1:0] scal_q
);
    logic [VEC_W-1:0]  ilv_v, shuf_v, ins_v, swp_v;
    logic [SCAL_W-1:0] ext_s;
    perm_res_t         nxt, res_q;

    perm_interleave #(.VEC_W(VEC_W)) u_ilv (
        .src_a (src_a),
        .src_b (src_b),
        .use_hi(op[2]),
        .gran  (op[1:0]),
        .ilv   (ilv_v)
    );

    perm_words #(
        .VEC_W (VEC_W),
        .WORD_W(WORD_W),
        .SCAL_W(SCAL_W),
        .IMM_W (IMM_W)
    ) u_words (
        .src_a  (src_a),
        .src_b  (src_b),
        .imm    (imm),
        .scal_in(scal_in),
        .shuf   (shuf_v),
        .ext    (ext_s),
        .ins    (ins_v),
        .swp    (swp_v)
    );

    always_comb begin
        nxt = '0;
        if (is_interleave(op)) begin
            nxt.vec = ilv_v;
        end else begin
            case (op)
                OP_EXTRACT: nxt.scal = ext_s;
                OP_INSERT:  nxt.vec  = ins_v;
                OP_SHUFFLE: nxt.vec  = shuf_v;
                OP_SWAP:    nxt.vec  = swp_v;
                default:    nxt      = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_q <= nxt;
            end
        end
    end

    assign vec_q  = res_q.vec;
    assign scal_q = res_q.scal;

endmodule

// File: rtl/perm_unit_chk.sv
module perm_unit_chk
    import perm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [OP_W-1:0]   op,
    input logic [VEC_W-1:0]  src_a,
    input logic [VEC_W-1:0]  src_b,
    input logic [IMM_W-1:0]  imm,
    input logic [SCAL_W-1:0] scal_in,
    input logic              out_valid,
    input logic [VEC_W-1:0]  vec_q,
    input logic [SCAL_W-1:0] scal_q
);
    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(vec_q) && $stable(scal_q)));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && vec_q == '0 && scal_q == '0));

    // R7
    swap_halves_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_SWAP) |=>
            (vec_q == {$past(src_b[31:0]), $past(src_b[63:32])}));

    // R3
    extract_zext_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_EXTRACT) |=>
            (scal_q[SCAL_W-1:WORD_W] == '0 && vec_q == '0));

    // R4
    insert_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_INSERT) |=>
            (vec_q[int'($past(imm[1:0]))*WORD_W +: WORD_W] == $past(scal_in[WORD_W-1:0])
             && scal_q == '0));

endmodule

bind perm_unit perm_unit_chk chk_i (.*);

// File: tb/perm_unit_tb_top.sv
`timescale 1ns/1ps
module perm_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [3:0]  op;
    logic [63:0] src_a, src_b;
    logic [7:0]  imm;
    logic [31:0] scal_in;
    logic        out_valid;
    logic [63:0] vec_q;
    logic [31:0] scal_q;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    perm_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .src_a(src_a), .src_b(src_b), .imm(imm), .scal_in(scal_in),
        .out_valid(out_valid), .vec_q(vec_q), .scal_q(scal_q)
    );

    localparam logic [63:0] A = 64'h8877665544332211;
    localparam logic [63:0] B = 64'hFFEEDDCCBBAA9988;

    typedef struct packed {
        logic [7:0]  tag;
        logic [3:0]  op;
        logic [63:0] a;
        logic [63:0] b;
        logic [7:0]  imm;
        logic [31:0] s;
        logic [63:0] ev;
        logic [31:0] es;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{8'd1,  4'd0,  A, B, 8'h00, 32'h0, 64'hBB44AA3399228811, 32'h0},        // R1
        '{8'd1,  4'd1,  A, B, 8'h00, 32'h0, 64'hBBAA443399882211, 32'h0},        // R1
        '{8'd1,  4'd2,  A, B, 8'h00, 32'h0, 64'hBBAA998844332211, 32'h0},        // R1
        '{8'd2,  4'd4,  A, B, 8'h00, 32'h0, 64'hFF88EE77DD66CC55, 32'h0},        // R2
        '{8'd2,  4'd5,  A, B, 8'h00, 32'h0, 64'hFFEE8877DDCC6655, 32'h0},        // R2
        '{8'd2,  4'd6,  A, B, 8'h00, 32'h0, 64'hFFEEDDCC88776655, 32'h0},        // R2
        '{8'd3,  4'd8,  A, B, 8'h02, 32'h0, 64'h0, 32'h0000DDCC},                // R3
        '{8'd3,  4'd8,  A, B, 8'h00, 32'h0, 64'h0, 32'h00009988},                // R3
        '{8'd5,  4'd8,  A, B, 8'hFF, 32'h0, 64'h0, 32'h0000FFEE},                // R5
        '{8'd4,  4'd9,  A, B, 8'h01, 32'hABCD1234, 64'h8877665512342211, 32'h0}, // R4
        '{8'd5,  4'd9,  A, B, 8'hFE, 32'hABCD1234, 64'h8877123444332211, 32'h0}, // R5
        '{8'd6,  4'd10, A, B, 8'h1B, 32'h0, 64'h9988BBAADDCCFFEE, 32'h0},        // R6
        '{8'd6,  4'd10, A, B, 8'h00, 32'h0, 64'h9988998899889988, 32'h0},        // R6
        '{8'd6,  4'd10, ~A, B, 8'hE4, 32'h0, B, 32'h0},                           // R6
        '{8'd7,  4'd11, A, B, 8'h00, 32'h0, 64'hBBAA9988FFEEDDCC, 32'h0},        // R7
        '{8'd10, 4'd3,  A, B, 8'hFF, 32'hFFFFFFFF, 64'h0, 32'h0}                 // R10
    };

    task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] o, input logic [63:0] a, input logic [63:0] b,
                         input logic [7:0] im, input logic [31:0] s);
        @(negedge clk);
        op = o; src_a = a; src_b = b; imm = im; scal_in = s;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; op = '0; src_a = '0; src_b = '0;
        imm = '0; scal_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        check("R9", {vec_q, scal_q}, 96'h0);
        check("R9", {95'h0, out_valid}, 96'h0);

        for (int i = 0; i < NV; i++) begin
            issue(TBL[i].op, TBL[i].a, TBL[i].b, TBL[i].imm, TBL[i].s);
            check($sformatf("R%0d", TBL[i].tag), {TBL[i].ev, TBL[i].es}, {vec_q, scal_q});
            check("R8", {95'h0, out_valid}, 96'h1);
        end

        // R1: upper halves changed, low interleave result unchanged
        issue(4'd0, 64'h0123456744332211, 64'h89ABCDEFBBAA9988, 8'h00, 32'h0);
        check("R1", {vec_q, scal_q}, {64'hBB44AA3399228811, 32'h0});
        // R2: lower halves changed, high interleave result unchanged
        issue(4'd5, 64'h8877665500000000, 64'hFFEEDDCC12345678, 8'h00, 32'h0);
        check("R2", {vec_q, scal_q}, {64'hFFEE8877DDCC6655, 32'h0});
        // R7: first source changed, swap unchanged
        issue(4'd11, 64'hDEADBEEFCAFEF00D, B, 8'h5A, 32'h1);
        check("R7", {vec_q, scal_q}, {64'hBBAA9988FFEEDDCC, 32'h0});
        // R10: other unused codes
        issue(4'd7, A, B, 8'h00, 32'h0);
        check("R10", {vec_q, scal_q}, 96'h0);
        issue(4'd15, A, B, 8'h00, 32'h0);
        check("R10", {vec_q, scal_q}, 96'h0);

        // R8: no request -> hold and no pulse
        issue(4'd11, A, B, 8'h00, 32'h0);
        @(negedge clk);
        op = 4'd0; src_a = ~A; src_b = ~B;
        @(negedge clk);
        check("R8", {vec_q, scal_q}, {64'hBBAA9988FFEEDDCC, 32'h0});
        check("R8", {95'h0, out_valid}, 96'h0);

        // R9: reset mid-stream clears result
        issue(4'd8, A, B, 8'h03, 32'h0);
        check("R3", {vec_q, scal_q}, {64'h0, 32'h0000FFEE});
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9", {vec_q, scal_q}, 96'h0);
        check("R9", {95'h0, out_valid}, 96'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule